// File: doc/BRIEF.md
# Peripheral soft-reset and clock-gate control register

This block is the control word at the top of a peripheral's register space. Software uses it to hold the peripheral in reset and to stop the peripheral clock. Bit 31 requests soft reset and bit 30 gates the clock. Bits 29:0 are general storage that soft reset returns to zero.

The word has three write aliases on a simple memory-mapped write port:

- Word offset 0 overwrites the word.
- Word offset 1 (byte 0x4) sets the bits written as 1.
- Word offset 2 (byte 0x8) clears the bits written as 1.

Software can therefore release reset and ungate the clock in separate steps without disturbing any other bit. The read data is the live word. Its top bit is the effective reset state, not the raw request.

A change of the reset request takes effect only after a settling window of `SETTLE_CYCLES` clocks. That window is modelled by a four-state machine:

- RUN: not in reset.
- ENTER: a reset request is waiting to settle.
- HELD: in reset.
- LEAVE: a release is waiting to settle.

The transitions are:

- RUN→ENTER: request set.
- ENTER→RUN: request withdrawn before it settles.
- ENTER→HELD: settled.
- HELD→LEAVE: request cleared.
- LEAVE→HELD: clear withdrawn.
- LEAVE→RUN: settled.

On ENTER→HELD the hardware sets the clock-gate bit by itself. Software polls for that bit to learn that the reset has completed.

Top module: `periph_srst_ctrl`

## Requirements
- R1: After system reset the read data is 0xC000_0000, and soft_reset_o and clk_gate_o are both 1.
- R2: A write at byte offset 0x0 loads the reset request from bit 31, the clock-gate bit from bit 30 and bits 29:0 from bits 29:0.
- R3: A write at offset 0x4 sets only the bits written as 1, and a write at offset 0x8 clears only the bits written as 1. A write at offset 0xC, or at any offset whose two low bits are not zero, changes nothing.
- R4: Read bit 31 and soft_reset_o take a new request value exactly SETTLE_CYCLES (default 3) rising edges after the edge that accepted the write.
- R5: If the request returns to the effective value before the window ends, the effective reset bit never changes.
- R6: At the edge where the effective reset rises, the clock-gate bit becomes 1.
- R7: If a software clear of the clock-gate bit lands on the same edge as the self-set, the bit ends up 1.
- R8: While the effective reset is 1, bits 29:0 read zero and writes to them are ignored. Entering reset zeroes them.
- R9: The read data is always {effective reset, clock gate, bits 29:0}. soft_reset_o equals read bit 31 and clk_gate_o equals read bit 30 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and peripheral clock |
| rst_ni | input | 1 | Active-low system reset, asynchronous |
| bus_wr_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr_i | input | ADDR_W | Byte offset of the write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Live register value |
| soft_reset_o | output | 1 | Effective soft reset to the peripheral |
| clk_gate_o | output | 1 | Clock-gate level to the peripheral |

## Verification
Two functions can fall on the same edge: the hardware self-set of the clock-gate bit at the end of ENTER, and a software clear-alias write to that same bit. The bench provokes this by issuing a set of bit 31 and then placing a clear of bit 30 exactly on the third edge after it. It judges the result by the gate reading 1 afterwards. Random alias writes also reverse pending requests inside the settling window. A bench model of the effective state and gate judges those cases every cycle.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_HELD  = 2'd2,
        ST_LEAVE = 2'd3
    } settle_state_e;

    typedef enum logic [1:0] {
        AL_NORMAL = 2'd0,
        AL_SET    = 2'd1,
        AL_CLEAR  = 2'd2,
        AL_NONE   = 2'd3
    } alias_e;
endpackage

// File: rtl/psc_alias_wr.sv
`timescale 1ns/1ps
module psc_alias_wr
    import psc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] cur_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] nxt_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    alias_e            kind;

    always_comb begin
        word = addr_i[ADDR_W-1:2];
        kind = AL_NONE;
        if (wr_i && addr_i[1:0] == 2'b00) begin
            if (word == WORD_W'(0))      kind = AL_NORMAL;
            else if (word == WORD_W'(1)) kind = AL_SET;
            else if (word == WORD_W'(2)) kind = AL_CLEAR;
        end
    end

    always_comb begin
        hit_o = 1'b1;
        unique case (kind)
            AL_NORMAL: nxt_o = wdata_i;
            AL_SET:    nxt_o = cur_i | wdata_i;
            AL_CLEAR:  nxt_o = cur_i & ~wdata_i;
            default: begin
                nxt_o = cur_i;
                hit_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/psc_settle.sv
`timescale 1ns/1ps
module psc_settle
    import psc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_nxt_i,
    output logic eff_o,
    output logic enter_done_o
);
    localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

    settle_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_HELD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: if (req_nxt_i) begin
                state_d = ST_ENTER;
                cnt_d   = CNT_LOAD;
            end
            ST_ENTER: begin
                if (!req_nxt_i)            state_d = ST_RUN;
                else if (cnt_q == '0)      state_d = ST_HELD;
                else                       cnt_d   = cnt_q - 1'b1;
            end
            ST_HELD: if (!req_nxt_i) begin
                state_d = ST_LEAVE;
                cnt_d   = CNT_LOAD;
            end
            ST_LEAVE: begin
                if (req_nxt_i)             state_d = ST_HELD;
                else if (cnt_q == '0)      state_d = ST_RUN;
                else                       cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_HELD;
        endcase
    end

    always_comb begin
        eff_o        = (state_q == ST_HELD) || (state_q == ST_LEAVE);
        enter_done_o = (state_q == ST_ENTER) && req_nxt_i && (cnt_q == '0);
    end
endmodule

// File: rtl/periph_srst_ctrl.sv
`timescale 1ns/1ps
module periph_srst_ctrl #(
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 4,
    parameter int SETTLE_CYCLES = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              soft_reset_o,
    output logic              clk_gate_o
);
    localparam int SRST_BIT = DATA_W - 1;
    localparam int GATE_BIT = DATA_W - 2;
    localparam int LOW_W    = DATA_W - 2;

    logic             req_q, gate_q, req_nxt, gate_nxt;
    logic [LOW_W-1:0] low_q, low_nxt;
    logic             wr_hit, eff, enter_done;
    logic [DATA_W-1:0] cur_word, wr_word;

    assign cur_word = {req_q, gate_q, low_q};

    psc_alias_wr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_alias (
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .cur_i   (cur_word),
        .hit_o   (wr_hit),
        .nxt_o   (wr_word)
    );

    assign req_nxt = wr_hit ? wr_word[SRST_BIT] : req_q;

    psc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_nxt_i    (req_nxt),
        .eff_o        (eff),
        .enter_done_o (enter_done)
    );

    always_comb begin
        if (enter_done)  gate_nxt = 1'b1;
        else if (wr_hit) gate_nxt = wr_word[GATE_BIT];
        else             gate_nxt = gate_q;

        if (eff || enter_done) low_nxt = '0;
        else if (wr_hit)       low_nxt = wr_word[LOW_W-1:0];
        else                   low_nxt = low_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q  <= 1'b1;
            gate_q <= 1'b1;
            low_q  <= '0;
        end else begin
            req_q  <= req_nxt;
            gate_q <= gate_nxt;
            low_q  <= low_nxt;
        end
    end

    assign bus_rdata_o  = {eff, gate_q, low_q};
    assign soft_reset_o = eff;
    assign clk_gate_o   = gate_q;
endmodule

// File: rtl/psc_checker.sv
`timescale 1ns/1ps
module psc_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              soft_reset_o,
    input logic              clk_gate_o,
    input logic              req_q
);
    // R6 / R7: the gate is up whenever the effective reset has just risen
    a_r6_gate_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(soft_reset_o) |-> clk_gate_o);

    // R8: storage bits are zero while in reset
    a_r8_low_zero_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_reset_o |-> (bus_rdata_o[DATA_W-3:0] == '0));

    // R4: the effective bit only ever moves toward the request
    a_r4_flip_follows_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(soft_reset_o) |-> (soft_reset_o == req_q));

    // R5: no change on the edge after request and effective value agree
    a_r5_no_flip_when_matched: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_q == soft_reset_o) |=> $stable(soft_reset_o));

    // R3: a write to the unused offset leaves request and storage alone
    a_r3_bad_offset_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == ADDR_W'(12)) |=>
            ($stable(req_q) && ($stable(bus_rdata_o[DATA_W-3:0]) || soft_reset_o)));
endmodule

bind periph_srst_ctrl psc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .bus_rdata_o  (bus_rdata_o),
    .soft_reset_o (soft_reset_o),
    .clk_gate_o   (clk_gate_o),
    .req_q        (req_q)
);

// File: tb/periph_srst_ctrl_tb.sv
`timescale 1ns/1ps
module periph_srst_ctrl_tb;
    localparam int SETTLE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        srst_o, gate_o;

    int checks = 0;
    int failures = 0;

    bit        m_req, m_eff, m_gate, m_busy;
    bit [29:0] m_low;
    int        m_left;

    always #2 clk = ~clk;

    periph_srst_ctrl #(.DATA_W(32), .ADDR_W(4), .SETTLE_CYCLES(SETTLE)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .soft_reset_o(srst_o), .clk_gate_o(gate_o)
    );

    function automatic logic [31:0] exp_word();
        return {m_eff, m_gate, m_low};
    endfunction

    task automatic model_edge(input bit w, input logic [3:0] a, input logic [31:0] d);
        logic [31:0] cur, nw;
        bit hit, nreq, rise, old_eff;
        cur = {m_req, m_gate, m_low};
        hit = 1'b0;
        nw  = cur;
        if (w && a == 4'h0) begin hit = 1'b1; nw = d; end
        if (w && a == 4'h4) begin hit = 1'b1; nw = cur | d; end
        if (w && a == 4'h8) begin hit = 1'b1; nw = cur & ~d; end
        nreq    = hit ? nw[31] : m_req;
        old_eff = m_eff;
        rise    = 1'b0;
        if (nreq == m_eff) m_busy = 1'b0;
        else if (!m_busy) begin m_busy = 1'b1; m_left = SETTLE - 1; end
        else if (m_left == 0) begin
            m_busy = 1'b0;
            rise   = nreq;
            m_eff  = nreq;
        end else m_left--;
        if (old_eff || rise) m_low = '0;
        else if (hit)        m_low = nw[29:0];
        if (rise)     m_gate = 1'b1;
        else if (hit) m_gate = nw[30];
        m_req = nreq;
    endtask

    task automatic check(input string tag);
        logic [31:0] e;
        e = exp_word();
        checks++;
        if (rdata !== e || srst_o !== e[31] || gate_o !== e[30]) begin
            failures++;
            $display("FAIL %s: rdata=%h srst=%b gate=%b expected rdata=%h srst=%b gate=%b",
                     tag, rdata, srst_o, gate_o, e, e[31], e[30]);
        end
    endtask

    task automatic step(input bit w, input logic [3:0] a, input logic [31:0] d, input string tag);
        wr = w; addr = a; wdata = d;
        @(posedge clk);
        model_edge(w, a, d);
        @(negedge clk);
        wr = 1'b0;
        check(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 4'h0, 32'h0, tag);
    endtask

    initial begin
        #800000;
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_req = 1; m_eff = 1; m_gate = 1; m_low = '0; m_busy = 0; m_left = 0;
        repeat (3) @(negedge clk);
        check("R1 reset value");
        rst_n = 1'b1;
        idle(1, "R1 after release");

        step(1'b1, 4'h0, 32'hC000_1234, "R8 write ignored in reset");
        step(1'b1, 4'h8, 32'h8000_0000, "R4 release write");
        idle(3, "R4 release settling");
        step(1'b1, 4'h8, 32'h4000_0000, "R3 clear gate");
        step(1'b1, 4'h0, 32'h00AB_CDEF, "R2 normal write");
        step(1'b1, 4'h4, 32'h0000_0F00, "R3 set alias");
        step(1'b1, 4'h8, 32'h0000_000F, "R3 clear alias");
        step(1'b1, 4'hC, 32'hFFFF_FFFF, "R3 unused offset");
        step(1'b1, 4'h1, 32'hFFFF_FFFF, "R3 misaligned offset");
        step(1'b1, 4'h0, 32'h4000_0055, "R2 normal write gate");
        step(1'b1, 4'h8, 32'h4000_0000, "R3 clear gate again");

        step(1'b1, 4'h4, 32'h8000_0000, "R5 request");
        idle(1, "R5 pending");
        step(1'b1, 4'h8, 32'h8000_0000, "R5 withdraw");
        idle(4, "R5 no change");

        step(1'b1, 4'h4, 32'h8000_0000, "R7 request");
        idle(2, "R7 pending");
        step(1'b1, 4'h8, 32'h4000_0000, "R7 clear on self-set edge");
        idle(2, "R7 gate held");

        step(1'b1, 4'h8, 32'h8000_0000, "R4 release");
        idle(1, "R5 leave pending");
        step(1'b1, 4'h4, 32'h8000_0000, "R5 leave withdrawn");
        idle(3, "R5 stays in reset");
        step(1'b1, 4'h8, 32'h8000_0000, "R4 release");
        idle(3, "R4 release settling");
        step(1'b1, 4'h8, 32'h4000_0000, "R3 ungate");
        step(1'b1, 4'h0, 32'h8000_0777, "R6 normal write request with gate 0");
        idle(3, "R6 gate self-set");

        for (int i = 0; i < 800; i++) begin
            logic [3:0] a;
            bit w;
            w = ($urandom % 4) != 0;
            case ($urandom % 5)
                0: a = 4'h0;
                1: a = 4'h4;
                2: a = 4'h8;
                3: a = 4'h8;
                default: a = 4'hC;
            endcase
            step(w, a, $urandom, "R9 random live readback");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule